// File: doc/BRIEF.md
# Barrier-Released Maintenance Operation Queue

This block sits next to a processor's system-control register port and holds back the effects of maintenance and register-write operations until the barrier that governs them arrives. Each accepted operation carries four encoding fields: a primary register number (`crn`, 4 bits), a first opcode (`op1`, 3 bits), a secondary register number (`crm`, 4 bits) and a second opcode (`op2`, 3 bits). It also carries a data word. The block decodes these fields into a release class. The class says which barrier (DMB, DSB or ISB) lets the operation through, or whether it needs no barrier.

Operations wait in an eight-entry buffer that keeps them in age order. A barrier pulse, an exception entry or an exception return marks entries as released. Released entries leave the commit port one per cycle, oldest first, and a younger operation never overtakes an older one. A configuration input, `defer_en`, turns deferral off. With deferral off, every operation is committed as soon as it is accepted. The block does not perform the cache, predictor or register effects, and it does not execute barriers. It only produces the ordered commit stream.

Top module: `deferred_maint_queue`

## Requirements
- R1: With `defer_en` low and the buffer empty, an accepted operation appears on the commit port (`cm_valid` high) in the cycle after it is accepted.
- R2: With `crn`=7 and `op1`=0, the `crm`/`op2` pairs 6/1, 10/1, 11/1, 14/1 and 5/4 need no barrier. When the buffer is empty they commit in the cycle after acceptance, even with `defer_en` high.
- R3: With deferral on, the pairs 1/0, 5/0 and 5/1 (`crn`=7, `op1`=0) are held until a DSB (`barrier_kind`=1). A DMB (`barrier_kind`=0) or an ISB (`barrier_kind`=2) leaves them pending.
- R4: With deferral on, the pairs 1/6, 5/6 and 5/7 (`crn`=7, `op1`=0) are held until an ISB. A DMB or a DSB leaves them pending.
- R5: With deferral on, the pairs 6/2, 10/2 and 14/2 (`crn`=7, `op1`=0) are released by either a DMB or a DSB.
- R6: Every other encoding, including `crn`=7 with a nonzero `op1`, is released only by an ISB, an exception entry or an exception return.
- R7: A pulse on `exc_entry` or `exc_return` releases every pending operation, whatever its class.
- R8: Commits leave one per cycle, in acceptance order. A barrier releases the oldest entries up to and including the youngest entry it matches. A barrier only acts on operations accepted in earlier cycles.
- R9: The buffer holds 8 operations. `in_ready` is low while 8 are held and rises again once entries drain.
- R10: A barrier or exception pulse that arrives while the buffer is empty has no effect. No commit appears, and the next deferred operation is still held.
- R11: After reset `cm_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| defer_en | input | 1 | 1: hold operations until their barrier; 0: commit at once |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Buffer has room; operation accepted when both are high |
| in_crn | input | 4 | Primary register number of the operation |
| in_op1 | input | 3 | First opcode field |
| in_crm | input | 4 | Secondary register number |
| in_op2 | input | 3 | Second opcode field |
| in_data | input | 32 | Operation payload |
| barrier_valid | input | 1 | Barrier executed this cycle |
| barrier_kind | input | 2 | 0 = DMB, 1 = DSB, 2 = ISB |
| exc_entry | input | 1 | Exception entry pulse |
| exc_return | input | 1 | Exception return pulse |
| cm_valid | output | 1 | Committed operation on the outputs this cycle |
| cm_crn | output | 4 | Primary register number of the commit |
| cm_op1 | output | 3 | First opcode of the commit |
| cm_crm | output | 4 | Secondary register number of the commit |
| cm_op2 | output | 3 | Second opcode of the commit |
| cm_data | output | 32 | Payload of the commit |

## Verification
The bench checks barrier kinds against the wrong classes: DMB and ISB against queued instruction-cache operations, DSB against predictor operations, and DMB and DSB against unclassified ones. A decoder that mapped any class to the wrong barrier would commit an operation the scoreboard does not expect. A mixed queue with a predictor entry between two instruction-cache entries and an immediate operation behind the first checks prefix release. A design that released only the matching entries, or let the immediate one overtake, would produce a misordered stream. Barriers on an empty buffer followed by a fresh deferred operation catch a design that latches a stale release. A full buffer checks that `in_ready` falls at exactly eight entries and returns after an exception drains them.

// File: rtl/dmq_pkg.sv
package dmq_pkg;

    localparam int CRN_W  = 4;
    localparam int OP1_W  = 3;
    localparam int CRM_W  = 4;
    localparam int OP2_W  = 3;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        CLS_NOW    = 3'd0,
        CLS_ICACHE = 3'd1,
        CLS_BPRED  = 3'd2,
        CLS_SETWAY = 3'd3,
        CLS_OTHER  = 3'd4
    } rel_cls_e;

    typedef enum logic [1:0] {
        BAR_DMB = 2'd0,
        BAR_DSB = 2'd1,
        BAR_ISB = 2'd2
    } bar_kind_e;

    typedef struct packed {
        logic [CRN_W-1:0]  crn;
        logic [OP1_W-1:0]  op1;
        logic [CRM_W-1:0]  crm;
        logic [OP2_W-1:0]  op2;
        logic [DATA_W-1:0] data;
    } mop_t;

    typedef struct packed {
        mop_t     op;
        rel_cls_e cls;
        logic     rel;
    } slot_t;

    // Whether a barrier of the given kind frees an entry of the given class.
    function automatic logic releases_on(rel_cls_e cls, bar_kind_e kind);
        case (cls)
            CLS_NOW:    releases_on = 1'b1;
            CLS_ICACHE: releases_on = (kind == BAR_DSB);
            CLS_BPRED:  releases_on = (kind == BAR_ISB);
            CLS_SETWAY: releases_on = (kind == BAR_DMB) || (kind == BAR_DSB);
            default:    releases_on = (kind == BAR_ISB);
        endcase
    endfunction

endpackage

// File: rtl/dmq_classify.sv
module dmq_classify
    import dmq_pkg::*;
(
    input  logic [CRN_W-1:0] crn,
    input  logic [OP1_W-1:0] op1,
    input  logic [CRM_W-1:0] crm,
    input  logic [OP2_W-1:0] op2,
    output rel_cls_e         cls
);

    always_comb begin
        cls = CLS_OTHER;
        if (crn == CRN_W'(7) && op1 == '0) begin
            case ({crm, op2})
                {4'd1, 3'd0}, {4'd5, 3'd0}, {4'd5, 3'd1}:
                    cls = CLS_ICACHE;
                {4'd1, 3'd6}, {4'd5, 3'd6}, {4'd5, 3'd7}:
                    cls = CLS_BPRED;
                {4'd6, 3'd1}, {4'd10, 3'd1}, {4'd11, 3'd1}, {4'd14, 3'd1}, {4'd5, 3'd4}:
                    cls = CLS_NOW;
                {4'd6, 3'd2}, {4'd10, 3'd2}, {4'd14, 3'd2}:
                    cls = CLS_SETWAY;
                default:
                    cls = CLS_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/dmq_prefix_scan.sv
module dmq_prefix_scan #(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0] hit,
    output logic [DEPTH-1:0] mask
);

    // mask[i] is set when slot i or any younger slot is hit.
    for (genvar g = 0; g < DEPTH; g++) begin : g_scan
        if (g == DEPTH - 1) begin : g_top
            assign mask[g] = hit[g];
        end else begin : g_mid
            assign mask[g] = hit[g] | mask[g+1];
        end
    end

endmodule

// File: rtl/dmq_pending_fifo.sv
module dmq_pending_fifo
    import dmq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  slot_t            push_slot,
    input  logic             pop,
    input  logic [DEPTH-1:0] rel_mask,
    output slot_t            slots [DEPTH],
    output logic [CW-1:0]    count
);

    slot_t         nxt [DEPTH];
    logic [CW-1:0] nxt_cnt;
    logic [CW-1:0] wr;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            nxt[i] = slots[i];
            if (rel_mask[i]) nxt[i].rel = 1'b1;
        end
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) nxt[i] = nxt[i+1];
            nxt[DEPTH-1] = '0;
        end
        wr = pop ? count - CW'(1) : count;
        if (push) nxt[wr[IW-1:0]] = push_slot;
        nxt_cnt = count + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
            count <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= nxt[i];
            count <= nxt_cnt;
        end
    end

endmodule

// File: rtl/deferred_maint_queue.sv
module deferred_maint_queue
    import dmq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              defer_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CRN_W-1:0]  in_crn,
    input  logic [OP1_W-1:0]  in_op1,
    input  logic [CRM_W-1:0]  in_crm,
    input  logic [OP2_W-1:0]  in_op2,
    input  logic [DATA_W-1:0] in_data,
    input  logic              barrier_valid,
    input  logic [1:0]        barrier_kind,
    input  logic              exc_entry,
    input  logic              exc_return,
    output logic              cm_valid,
    output logic [CRN_W-1:0]  cm_crn,
    output logic [OP1_W-1:0]  cm_op1,
    output logic [CRM_W-1:0]  cm_crm,
    output logic [OP2_W-1:0]  cm_op2,
    output logic [DATA_W-1:0] cm_data
);

    rel_cls_e         in_cls;
    slot_t            push_slot;
    slot_t            slots [DEPTH];
    logic [CW-1:0]    count;
    logic [DEPTH-1:0] occupied;
    logic [DEPTH-1:0] hit;
    logic [DEPTH-1:0] scan_mask;
    logic [DEPTH-1:0] rel_mask;
    logic             accept;
    bar_kind_e        kind;

    dmq_classify u_cls (
        .crn (in_crn),
        .op1 (in_op1),
        .crm (in_crm),
        .op2 (in_op2),
        .cls (in_cls)
    );

    assign kind     = bar_kind_e'(barrier_kind);
    assign in_ready = (count < CW'(DEPTH));
    assign accept   = in_valid && in_ready;

    always_comb begin
        push_slot.op.crn  = in_crn;
        push_slot.op.op1  = in_op1;
        push_slot.op.crm  = in_crm;
        push_slot.op.op2  = in_op2;
        push_slot.op.data = in_data;
        push_slot.cls     = in_cls;
        push_slot.rel     = !defer_en || (in_cls == CLS_NOW);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign occupied[g] = (CW'(g) < count);
        assign hit[g]      = occupied[g] && barrier_valid
                             && releases_on(slots[g].cls, kind);
    end

    dmq_prefix_scan #(.DEPTH(DEPTH)) u_scan (
        .hit  (hit),
        .mask (scan_mask)
    );

    assign rel_mask = (exc_entry || exc_return) ? occupied : scan_mask;

    assign cm_valid = (count != '0) && slots[0].rel;

    dmq_pending_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (accept),
        .push_slot (push_slot),
        .pop       (cm_valid),
        .rel_mask  (rel_mask),
        .slots     (slots),
        .count     (count)
    );

    assign cm_crn  = slots[0].op.crn;
    assign cm_op1  = slots[0].op.op1;
    assign cm_crm  = slots[0].op.crm;
    assign cm_op2  = slots[0].op.op2;
    assign cm_data = slots[0].op.data;

endmodule

// File: rtl/dmq_chk.sv
module dmq_chk
    import dmq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          defer_en,
    input logic          in_valid,
    input logic          in_ready,
    input logic          barrier_valid,
    input logic          exc_entry,
    input logic          exc_return,
    input logic          cm_valid,
    input logic [CW-1:0] count,
    input rel_cls_e      in_cls
);

    // R1
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (!defer_en && in_valid && in_ready && count == '0) |=> cm_valid);

    // R2
    immediate_class_chk: assert property (@(posedge clk) disable iff (rst)
        (defer_en && in_valid && in_ready && count == '0 && in_cls == CLS_NOW) |=> cm_valid);

    // R3
    icache_held_chk: assert property (@(posedge clk) disable iff (rst)
        (defer_en && in_valid && in_ready && count == '0 && in_cls == CLS_ICACHE
         && !exc_entry && !exc_return) |=> !cm_valid);

    // R7
    exception_release_chk: assert property (@(posedge clk) disable iff (rst)
        ((exc_entry || exc_return) && count != '0) |=> cm_valid);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R9
    fill_step_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !cm_valid) |=> (count == $past(count) + CW'(1)));

    // R10
    empty_barrier_chk: assert property (@(posedge clk) disable iff (rst)
        ((barrier_valid || exc_entry || exc_return) && count == '0
         && !(in_valid && in_ready)) |=> (count == '0 && !cm_valid));

endmodule

bind deferred_maint_queue dmq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .defer_en      (defer_en),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .barrier_valid (barrier_valid),
    .exc_entry     (exc_entry),
    .exc_return    (exc_return),
    .cm_valid      (cm_valid),
    .count         (count),
    .in_cls        (in_cls)
);

// File: tb/tb_deferred_maint_queue.sv
`timescale 1ns/1ps
module tb_deferred_maint_queue;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        defer_en = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_crn = '0;
    logic [2:0]  in_op1 = '0;
    logic [3:0]  in_crm = '0;
    logic [2:0]  in_op2 = '0;
    logic [31:0] in_data = '0;
    logic        barrier_valid = 1'b0;
    logic [1:0]  barrier_kind = '0;
    logic        exc_entry = 1'b0;
    logic        exc_return = 1'b0;
    logic        cm_valid;
    logic [3:0]  cm_crn;
    logic [2:0]  cm_op1;
    logic [3:0]  cm_crm;
    logic [2:0]  cm_op2;
    logic [31:0] cm_data;

    always #2 clk = ~clk;

    deferred_maint_queue dut (
        .clk(clk), .rst(rst), .defer_en(defer_en),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_crn(in_crn), .in_op1(in_op1), .in_crm(in_crm), .in_op2(in_op2),
        .in_data(in_data),
        .barrier_valid(barrier_valid), .barrier_kind(barrier_kind),
        .exc_entry(exc_entry), .exc_return(exc_return),
        .cm_valid(cm_valid), .cm_crn(cm_crn), .cm_op1(cm_op1),
        .cm_crm(cm_crm), .cm_op2(cm_op2), .cm_data(cm_data)
    );

    typedef struct {
        logic [3:0]  crn;
        logic [2:0]  op1;
        logic [3:0]  crm;
        logic [2:0]  op2;
        logic [31:0] data;
        int          cls;
        bit          rel;
        string       req;
    } item_t;

    item_t model_q[$];
    item_t exp_q[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    int    serial   = 1;
    bit    done     = 1'b0;

    // classes: 0 none needed, 1 icache (DSB), 2 predictor (ISB), 3 set/way (DMB/DSB), 4 other (ISB)
    function automatic int bench_cls(logic [3:0] crn, logic [2:0] op1, logic [3:0] crm, logic [2:0] op2);
        if (crn != 4'd7 || op1 != 3'd0) return 4;
        if ((crm == 1 && op2 == 0) || (crm == 5 && op2 == 0) || (crm == 5 && op2 == 1)) return 1;
        if ((crm == 1 && op2 == 6) || (crm == 5 && op2 == 6) || (crm == 5 && op2 == 7)) return 2;
        if ((crm == 6 && op2 == 2) || (crm == 10 && op2 == 2) || (crm == 14 && op2 == 2)) return 3;
        if ((crm == 6 || crm == 10 || crm == 11 || crm == 14) && op2 == 1) return 0;
        if (crm == 5 && op2 == 4) return 0;
        return 4;
    endfunction

    function automatic bit bench_frees(int cls, int kind);
        case (cls)
            0:       return 1'b1;
            1:       return kind == 1;
            2:       return kind == 2;
            3:       return kind == 0 || kind == 1;
            default: return kind == 2;
        endcase
    endfunction

    function automatic void drain_model();
        while (model_q.size() > 0 && model_q[0].rel) exp_q.push_back(model_q.pop_front());
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(logic [3:0] crn, logic [2:0] op1, logic [3:0] crm, logic [2:0] op2, string req);
        item_t it;
        bit    rdy;
        @(posedge clk); #1;
        in_valid = 1'b1; in_crn = crn; in_op1 = op1; in_crm = crm; in_op2 = op2;
        in_data = serial;
        #1 rdy = in_ready;
        @(posedge clk); #1;
        in_valid = 1'b0;
        if (rdy) begin
            it.crn = crn; it.op1 = op1; it.crm = crm; it.op2 = op2; it.data = serial;
            it.cls = bench_cls(crn, op1, crm, op2);
            it.rel = !defer_en || it.cls == 0;
            it.req = req;
            model_q.push_back(it);
            drain_model();
        end
        serial++;
    endtask

    task automatic barrier(int kind);
        int last;
        @(posedge clk); #1;
        barrier_valid = 1'b1; barrier_kind = 2'(kind);
        @(posedge clk); #1;
        barrier_valid = 1'b0;
        last = -1;
        foreach (model_q[i]) if (bench_frees(model_q[i].cls, kind)) last = i;
        for (int i = 0; i <= last; i++) model_q[i].rel = 1'b1;
        drain_model();
    endtask

    task automatic exception(bit is_return);
        @(posedge clk); #1;
        if (is_return) exc_return = 1'b1; else exc_entry = 1'b1;
        @(posedge clk); #1;
        exc_return = 1'b0; exc_entry = 1'b0;
        foreach (model_q[i]) model_q[i].rel = 1'b1;
        drain_model();
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic quiet(string req);
        repeat (3) @(negedge clk);
        check(cm_valid == 1'b0, req, "held entry committed", cm_valid, 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && cm_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected commit data", int'(cm_data), 0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(cm_crn == e.crn && cm_op1 == e.op1 && cm_crm == e.crm
                      && cm_op2 == e.op2 && cm_data == e.data,
                      e.req, "commit data", int'(cm_data), int'(e.data));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(cm_valid == 1'b0, "R11", "cm_valid after reset", cm_valid, 0);
        check(in_ready == 1'b1, "R11", "in_ready after reset", in_ready, 1);

        // R10 barriers on an empty buffer
        barrier(2); barrier(1); barrier(0); exception(1'b0);
        @(negedge clk);
        check(cm_valid == 1'b0 && in_ready == 1'b1, "R10", "empty barrier effect", cm_valid, 0);
        send(4'd7, 3'd0, 4'd1, 3'd0, "R10");
        quiet("R10");
        barrier(1);
        idle(3);

        // R1 deferral off
        defer_en = 1'b0;
        send(4'd7, 3'd0, 4'd5, 3'd0, "R1");
        send(4'd7, 3'd0, 4'd5, 3'd6, "R1");
        send(4'd2, 3'd1, 4'd0, 3'd0, "R1");
        idle(3);
        defer_en = 1'b1;

        // R2 immediate encodings
        send(4'd7, 3'd0, 4'd6, 3'd1, "R2");
        send(4'd7, 3'd0, 4'd10, 3'd1, "R2");
        send(4'd7, 3'd0, 4'd11, 3'd1, "R2");
        send(4'd7, 3'd0, 4'd14, 3'd1, "R2");
        send(4'd7, 3'd0, 4'd5, 3'd4, "R2");
        idle(3);

        // R3 instruction cache: only DSB
        send(4'd7, 3'd0, 4'd1, 3'd0, "R3");
        send(4'd7, 3'd0, 4'd5, 3'd0, "R3");
        send(4'd7, 3'd0, 4'd5, 3'd1, "R3");
        barrier(0); barrier(2);
        quiet("R3");
        barrier(1);
        idle(5);

        // R4 predictor: only ISB
        send(4'd7, 3'd0, 4'd1, 3'd6, "R4");
        send(4'd7, 3'd0, 4'd5, 3'd6, "R4");
        send(4'd7, 3'd0, 4'd5, 3'd7, "R4");
        barrier(0); barrier(1);
        quiet("R4");
        barrier(2);
        idle(5);

        // R5 set/way: DMB or DSB
        send(4'd7, 3'd0, 4'd6, 3'd2, "R5");
        send(4'd7, 3'd0, 4'd10, 3'd2, "R5");
        quiet("R5");
        barrier(0);
        idle(4);
        send(4'd7, 3'd0, 4'd14, 3'd2, "R5");
        quiet("R5");
        barrier(1);
        idle(4);

        // R6 unclassified: only ISB or exception
        send(4'd1, 3'd0, 4'd0, 3'd0, "R6");
        send(4'd7, 3'd1, 4'd5, 3'd0, "R6");
        send(4'd7, 3'd0, 4'd3, 3'd3, "R6");
        barrier(0); barrier(1);
        quiet("R6");
        barrier(2);
        idle(5);

        // R8 prefix release and ordering
        send(4'd7, 3'd0, 4'd1, 3'd0, "R8");
        send(4'd7, 3'd0, 4'd6, 3'd1, "R8");
        send(4'd7, 3'd0, 4'd5, 3'd6, "R8");
        send(4'd7, 3'd0, 4'd5, 3'd1, "R8");
        quiet("R8");
        barrier(2);
        idle(5);
        quiet("R8");
        barrier(1);
        idle(4);

        // R7 exception entry and return
        send(4'd7, 3'd0, 4'd1, 3'd0, "R7");
        send(4'd7, 3'd0, 4'd6, 3'd2, "R7");
        send(4'd3, 3'd2, 4'd1, 3'd1, "R7");
        quiet("R7");
        exception(1'b0);
        idle(5);
        send(4'd7, 3'd0, 4'd5, 3'd7, "R7");
        send(4'd9, 3'd0, 4'd0, 3'd5, "R7");
        quiet("R7");
        exception(1'b1);
        idle(5);

        // R9 full buffer
        for (int k = 0; k < 8; k++) send(4'd1, 3'(k), 4'd2, 3'd0, "R9");
        @(negedge clk);
        check(in_ready == 1'b0, "R9", "in_ready with 8 held", in_ready, 0);
        barrier(1);
        quiet("R9");
        @(negedge clk);
        check(in_ready == 1'b0, "R9", "in_ready still full", in_ready, 0);
        exception(1'b1);
        idle(12);
        @(negedge clk);
        check(in_ready == 1'b1, "R9", "in_ready after drain", in_ready, 1);

        idle(5);
        check(exp_q.size() == 0 && model_q.size() == 0, "R8", "items left outstanding",
              exp_q.size() + model_q.size(), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule